// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped register front end for up to 128 general purpose I/O lines, arranged as two banks of 64 lines. Software reads the (already synchronised) pin levels through a 64-bit input register, and changes output data only through a write-one-to-set register and a write-one-to-clear register. Because of this, several agents can change different output bits without a read-modify-write race.

Each line has its own configuration register. It holds output enable, polarity inversion, open-drain drive and a 10-bit function-select field. When the function-select field is nonzero, the line belongs to another function. GPIO set and clear writes then leave that line's output latch alone, and the block stops driving that line's pad.

The second bank is a copy of the first, placed at a fixed stride above it. A read-only constant register reports the line count and the base interrupt vector index.

Top module: `gpio_regctl`

## Requirements
- R1: After reset, every output latch bit and every configuration field is zero, `pad_oe` and `pad_out` are all zero, and `rdata` is zero.
- R2: A read is taken while `rd_en` is high and appears on `rdata` at the next cycle. Between reads, `rdata` holds its value. Reading offset 0x0 returns, for bit k, the pin input of line 64*bank+k XOR that line's invert bit.
- R3: Writing offset 0x8 sets every output latch bit whose data bit is 1 and leaves bits written 0 unchanged. Reading offset 0x8 or 0x10 returns the bank's output latch.
- R4: Writing offset 0x10 clears every output latch bit whose data bit is 1 and leaves bits written 0 unchanged.
- R5: The configuration register of bank line k is at offset 0x400 + 8*k. Its fields are: bit 0 output enable, bit 1 invert, bit 12 open-drain, and bits 25:16 function select. All other bits read as zero and ignore writes.
- R6: While a line's function-select field is nonzero, set and clear writes leave its output latch unchanged, and its `pad_oe` and `pad_out` are 0.
- R7: For a GPIO-owned line in push-pull mode (open-drain bit 0), `pad_oe` equals the output-enable bit and `pad_out` equals the output latch XOR the invert bit.
- R8: For a GPIO-owned line in open-drain mode, `pad_out` is 0 and `pad_oe` is high only when output enable is set and the latch XOR invert is 0.
- R9: Lines 64 to 127 are reached through the same register layout, offset by 0x1400.
- R10: Offset 0x90, in either bank, reads {48'b0, IRQ_BASE[7:0], NUM_LINES[7:0]}. Writes to it have no effect.
- R11: Any other offset, including unaligned ones, reads zero, and a write to it changes no latch, configuration or pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data on `rdata` next cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| pin_in | input | NUM_LINES | Synchronised pin levels |
| pad_oe | output | NUM_LINES | Pad output enable per line |
| pad_out | output | NUM_LINES | Pad output data per line |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge, and that `wr_en` and `rd_en` are never high together. They also assume that `addr` and `wdata` are stable for the whole strobe cycle, so that the set and clear properties can relate the strobe cycle directly to the latch one cycle later. The bench drives every strobe alone, for exactly one cycle, from the falling edge. It picks random set, clear and configuration writes and pin changes, and mixes them with directed cases: foreign-owned lines, open-drain with inversion, the upper bank, the constant register and unmapped or unaligned offsets.

// File: rtl/gpio_regctl_pkg.sv
package gpio_regctl_pkg;
   localparam int BANK_LINES  = 64;
   localparam int WORD_W      = 64;
   localparam int FUNC_W      = 10;
   localparam int MIN_ADDR_W  = 13;

   // byte offsets inside one bank
   localparam int OFS_RX      = 'h000;
   localparam int OFS_SET     = 'h008;
   localparam int OFS_CLR     = 'h010;
   localparam int OFS_CONST   = 'h090;
   localparam int OFS_CFG     = 'h400;
   localparam int BANK_STRIDE = 'h1400;

   typedef struct packed {
      logic [FUNC_W-1:0] func;
      logic              od;
      logic              inv;
      logic              oe;
   } line_cfg_t;

   function automatic logic [WORD_W-1:0] cfg_to_word(input line_cfg_t c);
      logic [WORD_W-1:0] w;
      w        = '0;
      w[0]     = c.oe;
      w[1]     = c.inv;
      w[12]    = c.od;
      w[25:16] = c.func;
      return w;
   endfunction

   function automatic line_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
      line_cfg_t c;
      c.oe   = w[0];
      c.inv  = w[1];
      c.od   = w[12];
      c.func = w[25:16];
      return c;
   endfunction
endpackage

// File: rtl/gpio_line_cfg.sv
module gpio_line_cfg
   import gpio_regctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [WORD_W-1:0] wdata,
   output line_cfg_t         cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_hit) cfg_q <= word_to_cfg(wdata);
   end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_LINES = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] set_mask,
   input  logic [NUM_LINES-1:0] clr_mask,
   input  logic [NUM_LINES-1:0] hold_mask,
   output logic [NUM_LINES-1:0] latch_q
);
   logic [NUM_LINES-1:0] set_eff;
   logic [NUM_LINES-1:0] clr_eff;

   assign set_eff = set_mask & ~hold_mask;
   assign clr_eff = clr_mask & ~hold_mask;

   // clear has priority over set on the same bit
   always_ff @(posedge clk) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q | set_eff) & ~clr_eff;
   end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_regctl_pkg::*;
(
   input  logic      latch_bit,
   input  line_cfg_t cfg,
   output logic      pad_oe,
   output logic      pad_out
);
   logic owned;
   logic eff;

   assign owned = (cfg.func == '0);
   assign eff   = latch_bit ^ cfg.inv;

   always_comb begin
      if (!owned) begin
         pad_oe  = 1'b0;
         pad_out = 1'b0;
      end else if (cfg.od) begin
         pad_oe  = cfg.oe & ~eff;
         pad_out = 1'b0;
      end else begin
         pad_oe  = cfg.oe;
         pad_out = eff;
      end
   end
endmodule

// File: rtl/gpio_regctl.sv
module gpio_regctl
   import gpio_regctl_pkg::*;
#(
   parameter int NUM_LINES = 128,
   parameter int ADDR_W    = 13,
   parameter int IRQ_BASE  = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic [NUM_LINES-1:0] pad_out
);
   localparam int NUM_BANKS = (NUM_LINES + BANK_LINES - 1) / BANK_LINES;
   localparam int IDX_W     = $clog2(BANK_LINES);
   localparam int LINE_W    = IDX_W + 1;

   if (NUM_LINES < 1 || NUM_LINES > 2 * BANK_LINES) begin : g_bad_lines
      $error("gpio_regctl: NUM_LINES must be 1..128");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_regctl: ADDR_W must cover both banks");
   end
   if (IRQ_BASE < 0 || IRQ_BASE > 255) begin : g_bad_irq
      $error("gpio_regctl: IRQ_BASE must fit in 8 bits");
   end

   // address decode
   logic              bank_idx;
   logic              bank_ok;
   logic [ADDR_W-1:0] off;
   logic              hit_rx, hit_set, hit_clr, hit_const, hit_cfg;
   logic [IDX_W-1:0]  cfg_idx;
   logic [LINE_W-1:0] cfg_line;

   always_comb begin
      bank_idx  = (addr >= ADDR_W'(BANK_STRIDE));
      off       = bank_idx ? (addr - ADDR_W'(BANK_STRIDE)) : addr;
      hit_rx    = (off == ADDR_W'(OFS_RX));
      hit_set   = (off == ADDR_W'(OFS_SET));
      hit_clr   = (off == ADDR_W'(OFS_CLR));
      hit_const = (off == ADDR_W'(OFS_CONST));
      hit_cfg   = (off >= ADDR_W'(OFS_CFG)) &&
                  (off <  ADDR_W'(OFS_CFG + 8 * BANK_LINES)) &&
                  (off[2:0] == 3'b000);
      cfg_idx   = off[IDX_W+2:3];
      cfg_line  = {bank_idx, cfg_idx};
   end

   // per-line state
   line_cfg_t            cfg_q [NUM_LINES];
   logic [NUM_LINES-1:0] out_latch;
   logic [NUM_LINES-1:0] line_od;
   logic [NUM_LINES-1:0] line_foreign;
   logic [NUM_LINES-1:0] line_hit;
   logic [NUM_LINES-1:0] eff_in;
   logic [NUM_LINES-1:0] set_mask;
   logic [NUM_LINES-1:0] clr_mask;
   logic [WORD_W-1:0]    cfg_word_line [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int BANK = i / BANK_LINES;
      localparam int BIT  = i % BANK_LINES;

      assign line_hit[i] = hit_cfg && (cfg_line == LINE_W'(i));
      assign set_mask[i] = wr_en && hit_set && (bank_idx == 1'(BANK)) && wdata[BIT];
      assign clr_mask[i] = wr_en && hit_clr && (bank_idx == 1'(BANK)) && wdata[BIT];

      gpio_line_cfg u_cfg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (wr_en && bank_ok && line_hit[i]),
         .wdata  (wdata),
         .cfg_q  (cfg_q[i])
      );

      gpio_pad_drive u_pad (
         .latch_bit (out_latch[i]),
         .cfg       (cfg_q[i]),
         .pad_oe    (pad_oe[i]),
         .pad_out   (pad_out[i])
      );

      assign line_od[i]       = cfg_q[i].od;
      assign line_foreign[i]  = (cfg_q[i].func != '0);
      assign eff_in[i]        = pin_in[i] ^ cfg_q[i].inv;
      assign cfg_word_line[i] = line_hit[i] ? cfg_to_word(cfg_q[i]) : '0;
   end

   gpio_out_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (set_mask),
      .clr_mask  (clr_mask),
      .hold_mask (line_foreign),
      .latch_q   (out_latch)
   );

   // bank words for the read path
   logic [WORD_W-1:0] rx_bank    [NUM_BANKS];
   logic [WORD_W-1:0] latch_bank [NUM_BANKS];
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] latch_word;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar k = 0; k < BANK_LINES; k++) begin : g_bit
         if (b * BANK_LINES + k < NUM_LINES) begin : g_live
            assign rx_bank[b][k]    = eff_in[b * BANK_LINES + k];
            assign latch_bank[b][k] = out_latch[b * BANK_LINES + k];
         end else begin : g_void
            assign rx_bank[b][k]    = 1'b0;
            assign latch_bank[b][k] = 1'b0;
         end
      end
   end

   if (NUM_BANKS == 1) begin : g_one_bank
      assign bank_ok    = !bank_idx;
      assign rx_word    = rx_bank[0];
      assign latch_word = latch_bank[0];
   end else begin : g_two_banks
      assign bank_ok    = 1'b1;
      assign rx_word    = rx_bank[bank_idx];
      assign latch_word = latch_bank[bank_idx];
   end

   logic [WORD_W-1:0] cfg_word;
   logic [WORD_W-1:0] const_word;
   logic [WORD_W-1:0] rd_word;

   assign const_word = {{(WORD_W-16){1'b0}}, 8'(IRQ_BASE), 8'(NUM_LINES)};

   always_comb begin
      cfg_word = '0;
      for (int i = 0; i < NUM_LINES; i++) cfg_word = cfg_word | cfg_word_line[i];
   end

   always_comb begin
      rd_word = '0;
      if (bank_ok) begin
         if (hit_rx)                 rd_word = rx_word;
         else if (hit_set || hit_clr) rd_word = latch_word;
         else if (hit_const)          rd_word = const_word;
         else if (hit_cfg)            rd_word = cfg_word;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end
endmodule

// File: rtl/gpio_regctl_chk.sv
module gpio_regctl_chk
   import gpio_regctl_pkg::*;
#(
   parameter int NUM_LINES = 128,
   parameter int ADDR_W    = 13
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [WORD_W-1:0]    wdata,
   input logic [WORD_W-1:0]    rdata,
   input logic [NUM_LINES-1:0] pad_oe,
   input logic [NUM_LINES-1:0] pad_out,
   input logic [NUM_LINES-1:0] out_latch,
   input logic [NUM_LINES-1:0] line_od,
   input logic [NUM_LINES-1:0] line_foreign
);
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R2

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      localparam int BANK = i / BANK_LINES;
      localparam int BIT  = i % BANK_LINES;
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BANK * BANK_STRIDE + OFS_SET);
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BANK * BANK_STRIDE + OFS_CLR);

      AST_FOREIGN_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         line_foreign[i] |-> (!pad_oe[i] && !pad_out[i])); // R6
      AST_FOREIGN_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         line_foreign[i] |=> $stable(out_latch[i])); // R6
      AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (!line_foreign[i] && line_od[i]) |-> !pad_out[i]); // R8
      AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == SET_A && wdata[BIT] && !line_foreign[i]) |=> out_latch[i]); // R3
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == CLR_A && wdata[BIT] && !line_foreign[i]) |=> !out_latch[i]); // R4
   end
endmodule

bind gpio_regctl gpio_regctl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_regctl_tb.sv
`timescale 1ns/1ps
module gpio_regctl_tb;
   localparam int N  = 128;
   localparam int AW = 13;
   localparam int IRQB = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [63:0]   wdata = '0;
   logic [63:0]   rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pad_oe;
   logic [N-1:0]  pad_out;

   always #2 clk = ~clk;

   gpio_regctl #(.NUM_LINES(N), .ADDR_W(AW), .IRQ_BASE(IRQB)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   // reference model
   bit [N-1:0] m_latch, m_oe, m_inv, m_od;
   bit [9:0]   m_func [N];

   function automatic bit [N-1:0] exp_oe();
      bit [N-1:0] v;
      for (int i = 0; i < N; i++) begin
         if (m_func[i] != 0) v[i] = 0;
         else if (m_od[i])   v[i] = m_oe[i] & ~(m_latch[i] ^ m_inv[i]);
         else                v[i] = m_oe[i];
      end
      return v;
   endfunction

   function automatic bit [N-1:0] exp_out();
      bit [N-1:0] v;
      for (int i = 0; i < N; i++)
         v[i] = (m_func[i] == 0 && !m_od[i]) ? (m_latch[i] ^ m_inv[i]) : 1'b0;
      return v;
   endfunction

   function automatic void model_write(input int a, input bit [63:0] d);
      int bank = (a >= 'h1400) ? 1 : 0;
      int off  = a - bank * 'h1400;
      for (int k = 0; k < 64; k++) begin
         int ln = bank * 64 + k;
         if (ln < N && d[k] && m_func[ln] == 0) begin
            if (off == 'h8)  m_latch[ln] = 1'b1;
            if (off == 'h10) m_latch[ln] = 1'b0;
         end
      end
      if (off >= 'h400 && off < 'h600 && off % 8 == 0) begin
         int ln = bank * 64 + (off - 'h400) / 8;
         m_oe[ln] = d[0]; m_inv[ln] = d[1]; m_od[ln] = d[12]; m_func[ln] = d[25:16];
      end
   endfunction

   function automatic bit [63:0] model_read(input int a);
      int bank = (a >= 'h1400) ? 1 : 0;
      int off  = a - bank * 'h1400;
      bit [63:0] v = '0;
      if (off == 0)
         for (int k = 0; k < 64; k++) v[k] = pin_in[bank*64+k] ^ m_inv[bank*64+k];
      else if (off == 'h8 || off == 'h10)
         for (int k = 0; k < 64; k++) v[k] = m_latch[bank*64+k];
      else if (off == 'h90)
         v = {48'b0, 8'(IRQB), 8'(N)};
      else if (off >= 'h400 && off < 'h600 && off % 8 == 0) begin
         int ln = bank * 64 + (off - 'h400) / 8;
         v[0] = m_oe[ln]; v[1] = m_inv[ln]; v[12] = m_od[ln]; v[25:16] = m_func[ln];
      end
      return v;
   endfunction

   task automatic check64(input string req, input bit [63:0] act, input bit [63:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic check_pads(input string req);
      n_checks++;
      if (pad_oe !== exp_oe() || pad_out !== exp_out()) begin
         n_fail++;
         $display("FAIL %s actual oe=%h out=%h expected oe=%h out=%h",
                  req, pad_oe, pad_out, exp_oe(), exp_out());
      end
   endtask

   task automatic bus_wr(input int a, input bit [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_rd(input int a, output bit [63:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_check(input string req, input int a);
      bit [63:0] d;
      bus_rd(a, d);
      check64(req, d, model_read(a));
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      bit [63:0] d;
      void'($urandom(32'h1a2b3c4d));
      for (int i = 0; i < N; i++) m_func[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check64("R1 pad_oe", 64'(pad_oe != 0), 64'd0);
      check64("R1 pad_out", 64'(pad_out != 0), 64'd0);
      check64("R1 rdata", rdata, 64'd0);
      rst_n = 1'b1;
      bus_rd('h8, d);    check64("R1 latch bank0", d, 64'd0);
      bus_rd('h1408, d); check64("R1 latch bank1", d, 64'd0);
      bus_rd('h400, d);  check64("R1 cfg line0", d, 64'd0);

      // R10 constant register in both banks, write has no effect
      bus_rd('h90, d);   check64("R10 const", d, 64'h3080);
      bus_wr('h90, '1);
      bus_rd('h1490, d); check64("R10 const bank1", d, 64'h3080);

      // R3 / R4 directed
      bus_wr('h8, 64'hF0F0_0000_0000_00FF);
      rd_check("R3 set readback", 'h8);
      bus_rd('h10, d); check64("R3 read via clr offset", d, 64'hF0F0_0000_0000_00FF);
      bus_wr('h10, 64'h8000_0000_0000_000F);
      bus_rd('h8, d); check64("R4 clear", d, 64'h70F0_0000_0000_00F0);

      // R5 all-ones config then restore
      bus_wr('h400 + 8*5, '1);
      bus_rd('h400 + 8*5, d); check64("R5 cfg fields", d, 64'h0000_0000_03FF_1003);
      bus_wr('h400 + 8*5, 64'h0);

      // R7 push-pull with inversion, R2 input inversion
      bus_wr('h400 + 8*4, 64'h3);   // oe + inv
      bus_wr('h400 + 8*6, 64'h1);   // oe
      check_pads("R7 push-pull");
      @(negedge clk) pin_in = {64'h0, 64'h0000_0000_0000_0050};
      rd_check("R2 rx inversion", 'h0);

      // R8 open drain with and without inversion
      bus_wr('h400 + 8*7, 64'h1001);
      bus_wr('h400 + 8*8, 64'h1003);
      bus_wr('h8, 64'h180);
      check_pads("R8 open-drain latch high");
      bus_wr('h10, 64'h180);
      check_pads("R8 open-drain latch low");

      // R6 foreign line ignores set/clear
      bus_wr('h400 + 8*3, 64'h0001_0001);
      bus_wr('h10, '1);
      bus_wr('h8, '1);
      bus_rd('h8, d); check64("R6 latch bit held", 64'(d[3]), 64'd0);
      check_pads("R6 pads idle");
      bus_wr('h400 + 8*3, 64'h1);
      bus_wr('h10, 64'h8);
      bus_wr('h8, 64'h8);
      rd_check("R6 released line takes set", 'h8);

      // R9 upper bank
      bus_wr('h1408, 64'h0000_0010_0000_0001);
      bus_wr('h1400 + 'h400 + 8*36, 64'h3);
      bus_rd('h1408, d); check64("R9 bank1 latch", d, 64'h0000_0010_0000_0001);
      rd_check("R9 bank1 cfg", 'h1400 + 'h400 + 8*36);
      check_pads("R9 bank1 pads");

      // R11 unmapped and unaligned
      bus_wr('h18, '1);
      bus_wr('h404, '1);
      bus_rd('h18, d);  check64("R11 unmapped read", d, 64'd0);
      bus_rd('h404, d); check64("R11 unaligned read", d, 64'd0);
      rd_check("R11 latch untouched", 'h8);
      rd_check("R11 cfg untouched", 'h400);
      check_pads("R11 pads untouched");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         int op   = int'($urandom % 4);
         int bank = int'($urandom % 2);
         int sel;
         bit [63:0] rnd = {$urandom, $urandom};
         case (op)
            0: bus_wr(bank * 'h1400 + 'h8, rnd & {$urandom, $urandom});
            1: bus_wr(bank * 'h1400 + 'h10, rnd & {$urandom, $urandom});
            2: begin
               bit [63:0] c = rnd;
               if ($urandom % 4 != 0) c[25:16] = 0;
               bus_wr(bank * 'h1400 + 'h400 + 8 * int'($urandom % 64), c);
            end
            default: begin
               @(negedge clk);
               pin_in = {$urandom, $urandom, $urandom, $urandom};
            end
         endcase
         check_pads("R7 R8 random pads");
         sel = int'($urandom % 5);
         case (sel)
            0: rd_check("R2 random rx", bank * 'h1400);
            1: rd_check("R3 random latch", bank * 'h1400 + 'h8);
            2: rd_check("R4 random latch", bank * 'h1400 + 'h10);
            3: rd_check("R5 random cfg", bank * 'h1400 + 'h400 + 8 * int'($urandom % 64));
            default: rd_check("R11 random hole", bank * 'h1400 + 'h20 + 8 * int'($urandom % 8));
         endcase
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule